// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Mailbox

This block takes interrupt messages arriving from a system bus and parks each one in a mailbox owned by the destination CPU. Each message names a target CPU and a source id, and carries two 64-bit data words. Every CPU has exactly one mailbox slot, which holds a busy flag, the source id and both data words.

A message is accepted only while its target slot is free. The accept/refuse answer is given in the same cycle, so a refused sender knows at once that it must retry. After an accepted message is stored, the block raises a post strobe toward the target CPU. The strobe carries a single interrupt vector that all CPUs share.

Software uses a small register port to read the stored words and the status, to program the shared vector, and to release a slot by clearing its busy flag. Every per-CPU register can be reached in two ways. Indexed addresses name the CPU explicitly. Alias addresses resolve to whichever CPU the requester id names, so a handler can reach its own slot without knowing its CPU number.

Top module: `bus_irq_mailbox`

## Requirements
- R1: After reset every busy flag, source id, data word and the vector register read as zero, and `postValid` is low.
- R2: `msgAccept` is high in the same cycle as `msgValid` exactly when the target slot is not busy. It is low when no message is offered. A refused message leaves the slot unchanged.
- R3: On the clock edge that ends an accepting cycle, the target slot becomes busy and stores the message's source id and both data words.
- R4: In the cycle after an acceptance, `postValid` is high and `postCpu` equals the accepted target. `postVec` equals the vector register as it stood in the accepting cycle. In any other cycle `postValid` is low.
- R5: A write to the vector word loads bits 5:0 of the write data. A read of it returns that value zero-extended. With N CPUs the vector word is at byte offset 8·(2N+3).
- R6: A status read returns the busy flag in bit 5 and the source id in bits 4:0, with all other bits zero. Indexed status for CPU k is at byte offset 8·(2N+4+k).
- R7: A status write loads the busy flag from write data bit 5 and leaves the source id unchanged. Writing 0 frees the slot, so the next message to that CPU is accepted. Writing bit 5 = 1 marks the slot busy, so messages to it are refused.
- R8: Data word 0 of CPU k reads at byte offset 8·k, and data word 1 at 8·(N+k). Read data is valid combinationally in the same cycle as the read request.
- R9: The alias addresses act on the slot named by `reqCpu`. Own data word 0 is at 8·2N, own data word 1 at 8·(2N+1), and own status at 8·(2N+2). The own-status alias works for both reads and writes.
- R10: When a message is accepted for CPU k in the same cycle as a status write to CPU k, the message wins: the slot ends up busy and holds the new source and data.
- R11: Writes to data-word addresses and to unmapped addresses change nothing. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgValid | input | 1 | Incoming message offered this cycle |
| msgCpu | input | CPU_W | Target CPU of the message |
| msgSrc | input | SRC_W | Source id of the message |
| msgData0 | input | DATA_W | First data word |
| msgData1 | input | DATA_W | Second data word |
| msgAccept | output | 1 | Message taken (high) or refused (low), same cycle |
| regValid | input | 1 | Register access this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte offset of the register |
| regWdata | input | DATA_W | Write data |
| reqCpu | input | CPU_W | CPU id of the requester, used by alias addresses |
| regRdata | output | DATA_W | Read data, combinational |
| postValid | output | 1 | Interrupt post strobe |
| postCpu | output | CPU_W | CPU the post is aimed at |
| postVec | output | VEC_W | Shared vector delivered with the post |

## Verification
The bench builds the block with NUM_CPU = 4 and the default 64-bit data and 8-bit address widths. With four slots, every slot can be filled and released within a few dozen cycles. The smaller map also leaves the upper half of the address space unmapped, which is what the zero-read and ignored-write checks need. At this size, same-cycle collisions can be set up directly: a message against a status write to the same slot, and a message against a vector write.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int IDX_W    = 5;
  localparam int BUSY_BIT = 5;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_D0,
    RD_D1,
    RD_ST,
    RD_VEC
  } rdSel_e;

  typedef struct packed {
    logic             msgLoad;
    logic [IDX_W-1:0] msgIdx;
    logic             stWrite;
    logic [IDX_W-1:0] stIdx;
    logic             stBusy;
    logic             vecWrite;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] rdIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/mbx_ctrl.sv
`timescale 1ns/1ps
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 64,
  localparam int CPU_W  = $clog2(NUM_CPU)
) (
  input  logic              msgValid,
  input  logic [CPU_W-1:0]  msgCpu,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [CPU_W-1:0]  reqCpu,
  input  logic [NUM_CPU-1:0] busyVec,
  output logic              msgAccept,
  output ctlStrobe_t        strobe
);
  localparam int WORD_W  = ADDR_W - 3;
  localparam int W_D1    = NUM_CPU;
  localparam int W_OWN0  = 2 * NUM_CPU;
  localparam int W_OWN1  = W_OWN0 + 1;
  localparam int W_OWNST = W_OWN0 + 2;
  localparam int W_VEC   = W_OWN0 + 3;
  localparam int W_ST    = W_OWN0 + 4;
  localparam int W_END   = W_ST + NUM_CPU;

  logic [WORD_W-1:0] wordIdx;
  int               w;
  rdSel_e           sel;
  logic [IDX_W-1:0] selIdx;

  assign wordIdx = regAddr[ADDR_W-1:3];
  assign w       = int'(wordIdx);

  always_comb begin
    sel    = RD_NONE;
    selIdx = '0;
    if (w < W_D1) begin
      sel    = RD_D0;
      selIdx = IDX_W'(w);
    end else if (w < W_OWN0) begin
      sel    = RD_D1;
      selIdx = IDX_W'(w - W_D1);
    end else if (w == W_OWN0) begin
      sel    = RD_D0;
      selIdx = IDX_W'(reqCpu);
    end else if (w == W_OWN1) begin
      sel    = RD_D1;
      selIdx = IDX_W'(reqCpu);
    end else if (w == W_OWNST) begin
      sel    = RD_ST;
      selIdx = IDX_W'(reqCpu);
    end else if (w == W_VEC) begin
      sel    = RD_VEC;
    end else if (w >= W_ST && w < W_END) begin
      sel    = RD_ST;
      selIdx = IDX_W'(w - W_ST);
    end
  end

  logic inRange;
  assign inRange   = int'(msgCpu) < NUM_CPU;
  assign msgAccept = msgValid && inRange && !busyVec[msgCpu];

  always_comb begin
    strobe          = '0;
    strobe.msgLoad  = msgAccept;
    strobe.msgIdx   = IDX_W'(msgCpu);
    strobe.stWrite  = regValid && regWrite && (sel == RD_ST);
    strobe.stIdx    = selIdx;
    strobe.stBusy   = regWdata[BUSY_BIT];
    strobe.vecWrite = regValid && regWrite && (sel == RD_VEC);
    strobe.rdSel    = (regValid && !regWrite) ? sel : RD_NONE;
    strobe.rdIdx    = selIdx;
  end
endmodule

// File: rtl/mbx_datapath.sv
`timescale 1ns/1ps
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int SRC_W   = 5,
  parameter int DATA_W  = 64,
  parameter int VEC_W   = 6,
  localparam int CPU_W  = $clog2(NUM_CPU)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [SRC_W-1:0]   msgSrc,
  input  logic [DATA_W-1:0]  msgData0,
  input  logic [DATA_W-1:0]  msgData1,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [NUM_CPU-1:0] busyVec,
  output logic [VEC_W-1:0]   vecVal,
  output logic [DATA_W-1:0]  regRdata,
  output logic               postValid,
  output logic [CPU_W-1:0]   postCpu,
  output logic [VEC_W-1:0]   postVec
);
  logic [SRC_W-1:0]  srcQ [NUM_CPU];
  logic [DATA_W-1:0] d0Q  [NUM_CPU];
  logic [DATA_W-1:0] d1Q  [NUM_CPU];
  logic [VEC_W-1:0]  vecQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyVec <= '0;
      for (int i = 0; i < NUM_CPU; i++) begin
        srcQ[i] <= '0;
        d0Q[i]  <= '0;
        d1Q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CPU; i++) begin
        if (strobe.msgLoad && strobe.msgIdx == IDX_W'(i)) begin
          busyVec[i] <= 1'b1;
          srcQ[i]    <= msgSrc;
          d0Q[i]     <= msgData0;
          d1Q[i]     <= msgData1;
        end else if (strobe.stWrite && strobe.stIdx == IDX_W'(i)) begin
          busyVec[i] <= strobe.stBusy;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vecQ <= '0;
    else if (strobe.vecWrite) vecQ <= regWdata[VEC_W-1:0];
  end
  assign vecVal = vecQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postValid <= 1'b0;
      postCpu   <= '0;
      postVec   <= '0;
    end else begin
      postValid <= strobe.msgLoad;
      if (strobe.msgLoad) begin
        postCpu <= strobe.msgIdx[CPU_W-1:0];
        postVec <= vecQ;
      end
    end
  end

  logic [CPU_W-1:0]  rIdx;
  logic [DATA_W-1:0] statWord;
  assign rIdx = strobe.rdIdx[CPU_W-1:0];

  always_comb begin
    statWord                 = '0;
    statWord[SRC_W-1:0]      = srcQ[rIdx];
    statWord[BUSY_BIT]       = busyVec[rIdx];
  end

  always_comb begin
    case (strobe.rdSel)
      RD_D0:   regRdata = d0Q[rIdx];
      RD_D1:   regRdata = d1Q[rIdx];
      RD_ST:   regRdata = statWord;
      RD_VEC:  regRdata = DATA_W'(vecQ);
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/bus_irq_mailbox.sv
`timescale 1ns/1ps
module bus_irq_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int SRC_W   = 5,
  parameter int DATA_W  = 64,
  parameter int VEC_W   = 6,
  parameter int ADDR_W  = 8,
  localparam int CPU_W  = $clog2(NUM_CPU)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  input  logic [CPU_W-1:0]  msgCpu,
  input  logic [SRC_W-1:0]  msgSrc,
  input  logic [DATA_W-1:0] msgData0,
  input  logic [DATA_W-1:0] msgData1,
  output logic              msgAccept,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [CPU_W-1:0]  reqCpu,
  output logic [DATA_W-1:0] regRdata,
  output logic              postValid,
  output logic [CPU_W-1:0]  postCpu,
  output logic [VEC_W-1:0]  postVec
);
  ctlStrobe_t         strobe;
  logic [NUM_CPU-1:0] busyVec;
  logic [VEC_W-1:0]   vecVal;

  mbx_ctrl #(
    .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .msgValid (msgValid),
    .msgCpu   (msgCpu),
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .reqCpu   (reqCpu),
    .busyVec  (busyVec),
    .msgAccept(msgAccept),
    .strobe   (strobe)
  );

  mbx_datapath #(
    .NUM_CPU(NUM_CPU), .SRC_W(SRC_W), .DATA_W(DATA_W), .VEC_W(VEC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .msgSrc   (msgSrc),
    .msgData0 (msgData0),
    .msgData1 (msgData1),
    .regWdata (regWdata),
    .busyVec  (busyVec),
    .vecVal   (vecVal),
    .regRdata (regRdata),
    .postValid(postValid),
    .postCpu  (postCpu),
    .postVec  (postVec)
  );
endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker #(
  parameter int NUM_CPU = 8,
  parameter int VEC_W   = 6,
  localparam int CPU_W  = $clog2(NUM_CPU)
) (
  input logic               clk,
  input logic               rstN,
  input logic               msgValid,
  input logic [CPU_W-1:0]   msgCpu,
  input logic               msgAccept,
  input logic               postValid,
  input logic [CPU_W-1:0]   postCpu,
  input logic [VEC_W-1:0]   postVec,
  input logic [NUM_CPU-1:0] busyVec,
  input logic [VEC_W-1:0]   vecVal
);
  p_refuse_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && busyVec[msgCpu]) |-> !msgAccept);

  p_no_accept_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !msgValid |-> !msgAccept);

  p_slot_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    msgAccept |=> busyVec[$past(msgCpu)]);

  p_post_follows_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    msgAccept |=> (postValid && postCpu == $past(msgCpu)));

  p_post_needs_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    postValid |-> $past(msgAccept));

  p_post_vector_r4: assert property (@(posedge clk) disable iff (!rstN)
    msgAccept |=> postVec == $past(vecVal));
endmodule

bind bus_irq_mailbox mbx_checker #(
  .NUM_CPU(NUM_CPU), .VEC_W(VEC_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .msgValid (msgValid),
  .msgCpu   (msgCpu),
  .msgAccept(msgAccept),
  .postValid(postValid),
  .postCpu  (postCpu),
  .postVec  (postVec),
  .busyVec  (busyVec),
  .vecVal   (vecVal)
);

// File: tb/tb_bus_irq_mailbox.sv
`timescale 1ns/1ps
module tb_bus_irq_mailbox;
  localparam int N      = 4;
  localparam int CPU_W  = $clog2(N);
  localparam int SRC_W  = 5;
  localparam int DATA_W = 64;
  localparam int VEC_W  = 6;
  localparam int ADDR_W = 8;

  logic clk = 0;
  logic rstN = 0;
  logic msgValid = 0;
  logic [CPU_W-1:0] msgCpu = '0;
  logic [SRC_W-1:0] msgSrc = '0;
  logic [DATA_W-1:0] msgData0 = '0, msgData1 = '0;
  logic msgAccept;
  logic regValid = 0, regWrite = 0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [CPU_W-1:0] reqCpu = '0;
  logic [DATA_W-1:0] regRdata;
  logic postValid;
  logic [CPU_W-1:0] postCpu;
  logic [VEC_W-1:0] postVec;

  always #2 clk = ~clk;

  bus_irq_mailbox #(.NUM_CPU(N), .SRC_W(SRC_W), .DATA_W(DATA_W),
                    .VEC_W(VEC_W), .ADDR_W(ADDR_W)) dut (.*);

  int checks = 0, failures = 0;

  // reference model state
  bit          mBusy [N];
  int          mSrc  [N];
  logic [63:0] mD0   [N];
  logic [63:0] mD1   [N];
  int          mVec;
  bit          mPostV;
  int          mPostCpu, mPostVec;

  function automatic void chk(bit ok, string req, string what,
                              logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [63:0] statOf(int k);
    return 64'(mSrc[k]) | (mBusy[k] ? 64'h20 : 64'h0);
  endfunction

  function automatic logic [63:0] expRead(int addr, int rq);
    int w = addr / 8;
    if (w < N) return mD0[w];
    if (w < 2*N) return mD1[w-N];
    if (w == 2*N) return mD0[rq];
    if (w == 2*N+1) return mD1[rq];
    if (w == 2*N+2) return statOf(rq);
    if (w == 2*N+3) return 64'(mVec);
    if (w >= 2*N+4 && w < 3*N+4) return statOf(w-(2*N+4));
    return 64'h0;
  endfunction

  // one clock: drive, check combinational and post outputs, clock, update model
  task automatic cyc(bit mv, int mc, int ms, logic [63:0] a, logic [63:0] b,
                     bit rv, bit rw, int addr, logic [63:0] wd, int rq, string req);
    bit expAcc;
    int oldVec;
    int w;
    msgValid = mv; msgCpu = CPU_W'(mc); msgSrc = SRC_W'(ms);
    msgData0 = a; msgData1 = b;
    regValid = rv; regWrite = rw; regAddr = ADDR_W'(addr); regWdata = wd;
    reqCpu = CPU_W'(rq);
    #1;
    expAcc = mv && !mBusy[mc];
    chk(msgAccept == expAcc, mv ? req : "R2", "msgAccept", 64'(msgAccept), 64'(expAcc));
    if (rv && !rw)
      chk(regRdata == expRead(addr, rq), req, "regRdata", regRdata, expRead(addr, rq));
    chk(postValid == mPostV, "R4", "postValid", 64'(postValid), 64'(mPostV));
    if (mPostV) begin
      chk(int'(postCpu) == mPostCpu, "R4", "postCpu", 64'(postCpu), 64'(mPostCpu));
      chk(int'(postVec) == mPostVec, "R4", "postVec", 64'(postVec), 64'(mPostVec));
    end
    @(posedge clk);
    oldVec = mVec;
    w = addr / 8;
    if (rv && rw) begin
      if (w == 2*N+2) mBusy[rq] = wd[5];
      else if (w >= 2*N+4 && w < 3*N+4) mBusy[w-(2*N+4)] = wd[5];
      else if (w == 2*N+3) mVec = int'(wd[5:0]);
    end
    if (expAcc) begin   // R10: message wins over same-cycle status write
      mBusy[mc] = 1; mSrc[mc] = ms; mD0[mc] = a; mD1[mc] = b;
    end
    mPostV = expAcc;
    if (expAcc) begin mPostCpu = mc; mPostVec = oldVec; end
    @(negedge clk);
  endtask

  task automatic msg(int c, int s, logic [63:0] a, logic [63:0] b, string req);
    cyc(1, c, s, a, b, 0, 0, 0, 0, 0, req);
  endtask
  task automatic rd(int addr, int rq, string req);
    cyc(0, 0, 0, 0, 0, 1, 0, addr, 0, rq, req);
  endtask
  task automatic wr(int addr, logic [63:0] d, int rq, string req);
    cyc(0, 0, 0, 0, 0, 1, 1, addr, d, rq, req);
  endtask

  localparam int A_OWN0 = 8*(2*N);
  localparam int A_OWN1 = 8*(2*N+1);
  localparam int A_OWNS = 8*(2*N+2);
  localparam int A_VEC  = 8*(2*N+3);
  function automatic int aSt(int k); return 8*(2*N+4+k); endfunction
  function automatic int aD0(int k); return 8*k; endfunction
  function automatic int aD1(int k); return 8*(N+k); endfunction

  initial begin
    #(200000*4);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mBusy[i]=0; mSrc[i]=0; mD0[i]=0; mD1[i]=0; end
    mVec = 0; mPostV = 0; mPostCpu = 0; mPostVec = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: whole address space reads zero after reset (incl. unmapped, R11)
    for (int a = 0; a < 256; a += 8) rd(a, 0, "R1");
    // R5: vector keeps only bits 5:0
    wr(A_VEC, 64'hFFC0_002A | 64'hC0, 0, "R5");
    rd(A_VEC, 0, "R5");
    // R3/R4: accept into CPU1
    msg(1, 5'h13, 64'hDEAD_BEEF_0000_0001, 64'h1234_5678_9ABC_DEF0, "R2");
    rd(aSt(1), 0, "R6");
    rd(aD0(1), 0, "R8");
    rd(aD1(1), 0, "R8");
    // R2: refused while busy; slot unchanged
    msg(1, 5'h07, 64'h1, 64'h2, "R2");
    rd(aD0(1), 0, "R2");
    rd(aSt(1), 0, "R2");
    // R9: own aliases
    rd(A_OWN0, 1, "R9");
    rd(A_OWN1, 1, "R9");
    rd(A_OWNS, 1, "R9");
    rd(A_OWNS, 2, "R9");
    // R7/R9: release via own alias, source kept
    wr(A_OWNS, 64'h0, 1, "R9");
    rd(aSt(1), 0, "R7");
    msg(1, 5'h1F, 64'hAAAA, 64'hBBBB, "R7");
    rd(aSt(1), 0, "R7");
    // R7: software sets busy on CPU2, message refused
    wr(aSt(2), 64'h20, 0, "R7");
    msg(2, 5'h04, 64'h5, 64'h6, "R7");
    rd(aSt(2), 0, "R7");
    // R10: message and status write to same slot in one cycle
    cyc(1, 3, 5'h0A, 64'hC0FFEE, 64'hF00D, 1, 1, aSt(3), 64'h0, 0, "R10");
    rd(aSt(3), 0, "R10");
    rd(aD0(3), 0, "R10");
    // R4: vector write in accepting cycle -> post carries old vector
    wr(aSt(2), 64'h0, 0, "R7");
    cyc(1, 2, 5'h11, 64'h77, 64'h88, 1, 1, A_VEC, 64'h15, 0, "R4");
    rd(A_VEC, 0, "R5");
    // R11: writes to data words and unmapped addresses ignored
    wr(aD0(1), 64'hFFFF_FFFF, 0, "R11");
    wr(aD1(1), 64'hFFFF_FFFF, 0, "R11");
    wr(8'hC0, 64'hFFFF_FFFF, 0, "R11");
    rd(aD0(1), 0, "R11");
    rd(aD1(1), 0, "R11");
    rd(8'hC0, 0, "R11");
    // fill all, release all, refill with back-to-back messages
    msg(0, 5'h01, 64'h10, 64'h20, "R3");
    for (int k = 0; k < N; k++) msg(k, 5'h02, 64'h30, 64'h40, "R2");
    for (int k = 0; k < N; k++) wr(aSt(k), 64'h0, 0, "R7");
    for (int k = 0; k < N; k++) msg(k, k + 8, 64'(k) << 32, 64'(~k), "R3");
    for (int k = 0; k < N; k++) begin
      rd(aSt(k), 0, "R6");
      rd(aD0(k), 0, "R8");
      rd(aD1(k), 0, "R8");
    end
    for (int k = 0; k < N; k++) rd(A_OWNS, k, "R9");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule